// File: doc/BRIEF.md
# Hash Accelerator Control Register Block

This block is the software-facing register file of a DMA-driven hash accelerator. A processor programs the source buffer, the digest destination and the key buffer through 32-bit register writes. Each address is split into a low word and a narrow high word. The processor also sets the byte length of the source and then writes a command word. The block masks every address field as it is written. It composes full 64-bit DMA addresses for the engine that sits behind it, and it gives that engine a one-cycle start pulse together with the decoded mode fields.

Every command write marks completion in a status register, and this happens whether or not an interrupt was requested. The interrupt line is raised only when the command asked for one. Software clears both the completion flag and the interrupt by writing a one to the flag. The hash datapath and the memory transfers live outside this block.

The command word uses these fields:
- bits [2:0] select the algorithm.
- bit 8 enables scatter-gather.
- bit 9 enables the interrupt.
- bits [11:10] equal to 2'b10 select accumulate mode.

Reads are combinational on the offset.

Top module: `hash_csr`

## Requirements
- R1: After reset every mapped register reads zero, and `start`, `irq` and all composed address outputs are low.
- R2: A write to offset 0x20 (source low) stores the data ANDed with 0x7FFFFFFF.
- R3: Writes to offsets 0x24 (digest low) and 0x28 (key low) store the data ANDed with 0x7FFFFFF8, so bits [2:0] of those addresses are always zero.
- R4: Writes to offsets 0x90, 0x94 and 0x98 (source, digest and key high words) keep only bits [1:0].
- R5: With 64-bit DMA enabled, each composed address is {high word, low word}. With it disabled, bits [63:32] of each composed address are zero and the high-word offsets read zero.
- R6: A write to offset 0x2C stores the full 32-bit source length, which appears on `src_len` and reads back unchanged.
- R7: A write to offset 0x30 whose bits [2:0] name a supported algorithm (codes 0 to 3 by default) drives `start` high for exactly the one cycle after the write edge. The command word reads back unchanged. `algo`, `sg_en` (bit 8) and `accum` (bits [11:10] == 2'b10) reflect the stored command.
- R8: A command write with an unsupported algorithm code (4 to 7 by default) produces no `start` pulse but still sets the completion flag.
- R9: Every command write sets bit 0 of the status register at offset 0x1C, independent of bit 9. `irq` rises after a command write only if bit 9 of that command is one.
- R10: Writing 1 to status bit 0 clears the completion flag and drops `irq`. Writing 0 there changes neither.
- R11: Reads of any offset other than 0x1C, 0x20, 0x24, 0x28, 0x2C, 0x30, 0x90, 0x94 and 0x98 return zero. This includes offsets at or beyond the 0x9C window end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| start | output | 1 | One-cycle operation start pulse |
| algo | output | 3 | Algorithm select from the command |
| sg_en | output | 1 | Scatter-gather enable from the command |
| accum | output | 1 | Accumulate mode from the command |
| src_addr | output | 64 | Composed source DMA address |
| dig_addr | output | 64 | Composed digest DMA address |
| key_addr | output | 64 | Composed key buffer DMA address |
| src_len | output | 32 | Source length in bytes |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds two copies of the block side by side: `u0` with 64-bit DMA enabled and `u1` with it disabled. Both receive the same write stream. This lets one behavioural model check, on every clock, both the composed high address bits and the read-back of the high-word registers, which are kept in one variant and zeroed in the other. The default algorithm-support mask (codes 0 to 3) is kept, so that both valid and invalid command codes can be issued.

// File: rtl/hash_csr.sv
module hash_csr #(
  parameter bit          DMA64       = 1'b1,
  parameter int          AW          = 8,
  parameter logic [31:0] SRC_LO_MASK = 32'h7FFF_FFFF,
  parameter logic [31:0] ALN_LO_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] HI_MASK     = 32'h0000_0003,
  parameter logic [7:0]  ALGO_OK     = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          start,
  output logic [2:0]    algo,
  output logic          sg_en,
  output logic          accum,
  output logic [63:0]   src_addr,
  output logic [63:0]   dig_addr,
  output logic [63:0]   key_addr,
  output logic [31:0]   src_len,
  output logic          irq
);
  localparam logic [AW-1:0] OFF_STAT = AW'('h1C);
  localparam logic [AW-1:0] OFF_SRC  = AW'('h20);
  localparam logic [AW-1:0] OFF_DIG  = AW'('h24);
  localparam logic [AW-1:0] OFF_KEY  = AW'('h28);
  localparam logic [AW-1:0] OFF_LEN  = AW'('h2C);
  localparam logic [AW-1:0] OFF_CMD  = AW'('h30);
  localparam logic [AW-1:0] OFF_SRCH = AW'('h90);
  localparam logic [AW-1:0] OFF_DIGH = AW'('h94);
  localparam logic [AW-1:0] OFF_KEYH = AW'('h98);
  localparam int IRQ_BIT = 9;
  localparam int SG_BIT  = 8;

  logic [31:0] src_lo, dig_lo, key_lo, src_hi, dig_hi, key_hi, len_q, cmd_q;
  logic [31:0] src_hv, dig_hv, key_hv;
  logic        done_q, irq_q, start_q;

  wire cmd_wr   = wr_en && addr == OFF_CMD;
  wire stat_clr = wr_en && addr == OFF_STAT && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_lo <= '0; dig_lo <= '0; key_lo <= '0;
      src_hi <= '0; dig_hi <= '0; key_hi <= '0;
      len_q  <= '0; cmd_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_SRC:  src_lo <= wdata & SRC_LO_MASK;
        OFF_DIG:  dig_lo <= wdata & ALN_LO_MASK;
        OFF_KEY:  key_lo <= wdata & ALN_LO_MASK;
        OFF_LEN:  len_q  <= wdata;
        OFF_CMD:  cmd_q  <= wdata;
        OFF_SRCH: src_hi <= wdata & HI_MASK;
        OFF_DIGH: dig_hi <= wdata & HI_MASK;
        OFF_KEYH: key_hi <= wdata & HI_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= cmd_wr && ALGO_OK[wdata[2:0]];
      if (cmd_wr) begin
        done_q <= 1'b1;
        if (wdata[IRQ_BIT]) irq_q <= 1'b1;
      end else if (stat_clr) begin
        done_q <= 1'b0;
        irq_q  <= 1'b0;
      end
    end
  end

  generate
    if (DMA64) begin : g_wide
      assign src_hv = src_hi;
      assign dig_hv = dig_hi;
      assign key_hv = key_hi;
    end else begin : g_narrow
      assign src_hv = '0;
      assign dig_hv = '0;
      assign key_hv = '0;
    end
  endgenerate

  assign src_addr = {src_hv, src_lo};
  assign dig_addr = {dig_hv, dig_lo};
  assign key_addr = {key_hv, key_lo};
  assign src_len  = len_q;
  assign start    = start_q;
  assign irq      = irq_q;
  assign algo     = cmd_q[2:0];
  assign sg_en    = cmd_q[SG_BIT];
  assign accum    = cmd_q[11:10] == 2'b10;

  always_comb begin
    case (addr)
      OFF_STAT: rdata = {31'd0, done_q};
      OFF_SRC:  rdata = src_lo;
      OFF_DIG:  rdata = dig_lo;
      OFF_KEY:  rdata = key_lo;
      OFF_LEN:  rdata = len_q;
      OFF_CMD:  rdata = cmd_q;
      OFF_SRCH: rdata = src_hv;
      OFF_DIGH: rdata = dig_hv;
      OFF_KEYH: rdata = key_hv;
      default:  rdata = '0;
    endcase
  end

  // R7
  start_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(wr_en && addr == OFF_CMD && ALGO_OK[wdata[2:0]]));
  // R9
  done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CMD) |=> rdata_done_seen());
  // R9
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q);
  // R10
  w1c_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_STAT && wdata[0]) |=> !irq && !done_q);
  // R3
  dig_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dig_addr[2:0] == 3'd0 && key_addr[2:0] == 3'd0);

  function automatic logic rdata_done_seen();
    return done_q;
  endfunction
endmodule

// File: tb/sim_hash_csr.sv
module sim_hash_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;

  logic [31:0] rd0, rd1, len0, len1;
  logic        st0, st1, sg0, sg1, ac0, ac1, irq0, irq1;
  logic [2:0]  al0, al1;
  logic [63:0] sa0, da0, ka0, sa1, da1, ka1;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  hash_csr #(.DMA64(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rd0), .start(st0), .algo(al0), .sg_en(sg0), .accum(ac0),
    .src_addr(sa0), .dig_addr(da0), .key_addr(ka0), .src_len(len0), .irq(irq0));
  hash_csr #(.DMA64(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rd1), .start(st1), .algo(al1), .sg_en(sg1), .accum(ac1),
    .src_addr(sa1), .dig_addr(da1), .key_addr(ka1), .src_len(len1), .irq(irq1));

  // behavioural reference
  logic [31:0] m_src, m_dig, m_key, m_sh, m_dh, m_kh, m_len, m_cmd;
  logic        m_done, m_irq, m_start;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_dig = 0; m_key = 0; m_sh = 0; m_dh = 0; m_kh = 0;
      m_len = 0; m_cmd = 0; m_done = 0; m_irq = 0; m_start = 0;
    end else begin
      m_start = wr_en && addr == 8'h30 && wdata[2:0] < 3'd4;
      if (wr_en) begin
        if (addr == 8'h20) m_src = wdata % 32'h8000_0000;
        if (addr == 8'h24) m_dig = (wdata % 32'h8000_0000) / 8 * 8;
        if (addr == 8'h28) m_key = (wdata % 32'h8000_0000) / 8 * 8;
        if (addr == 8'h2C) m_len = wdata;
        if (addr == 8'h90) m_sh = wdata % 4;
        if (addr == 8'h94) m_dh = wdata % 4;
        if (addr == 8'h98) m_kh = wdata % 4;
        if (addr == 8'h30) begin
          m_cmd = wdata; m_done = 1;
          if (wdata[9]) m_irq = 1;
        end
        if (addr == 8'h1C && wdata[0]) begin m_done = 0; m_irq = 0; end
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a, input bit wide);
    case (a)
      8'h1C: return {31'd0, m_done};
      8'h20: return m_src;
      8'h24: return m_dig;
      8'h28: return m_key;
      8'h2C: return m_len;
      8'h30: return m_cmd;
      8'h90: return wide ? m_sh : 32'd0;
      8'h94: return wide ? m_dh : 32'd0;
      8'h98: return wide ? m_kh : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h1C: return "R9";
      8'h20: return "R2";
      8'h24, 8'h28: return "R3";
      8'h2C: return "R6";
      8'h30: return "R7";
      8'h90, 8'h94, 8'h98: return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R7 start u0", st0, m_start);
      chk("R7 start u1", st1, m_start);
      chk("R9 irq u0", irq0, m_irq);
      chk("R9 irq u1", irq1, m_irq);
      chk("R7 algo", al0, m_cmd[2:0]);
      chk("R7 sg_en", sg0, m_cmd[8]);
      chk("R7 accum", ac0, m_cmd[11:10] == 2'b10);
      chk("R6 src_len", len1, m_len);
      chk("R5 src_addr u0", sa0, {m_sh, m_src});
      chk("R5 dig_addr u0", da0, {m_dh, m_dig});
      chk("R5 key_addr u0", ka0, {m_kh, m_key});
      chk("R5 src_addr u1", sa1, {32'd0, m_src});
      chk("R5 key_addr u1", ka1, {32'd0, m_key});
      chk({tag_of(addr), " rdata u0"}, rd0, m_read(addr, 1'b1));
      chk({"R5 ", tag_of(addr), " rdata u1"}, rd1, m_read(addr, 1'b0));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] e0, input logic [31:0] e1);
    @(negedge clk); addr = a; #1;
    chk(tag, rd0, e0);
    chk(tag, rd1, e1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    foreach (m_read_list[i]) rd("R1 reset read", m_read_list[i], 0, 0);
    chk("R1 start", st0, 0); chk("R1 irq", irq0, 0); chk("R1 src_addr", sa0, 0);
    // R2
    wr(8'h20, 32'hFFFF_FFFF); rd("R2 src mask", 8'h20, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    // R3
    wr(8'h24, 32'hFFFF_FFFF); rd("R3 dig mask", 8'h24, 32'h7FFF_FFF8, 32'h7FFF_FFF8);
    wr(8'h28, 32'h1234_5677); rd("R3 key mask", 8'h28, 32'h1234_5670, 32'h1234_5670);
    // R4 / R5
    wr(8'h90, 32'hFFFF_FFFF); rd("R4 src hi", 8'h90, 32'h3, 32'h0);
    wr(8'h94, 32'hFFFF_FFFE); rd("R4 dig hi", 8'h94, 32'h2, 32'h0);
    wr(8'h98, 32'h0000_0005); rd("R4 key hi", 8'h98, 32'h1, 32'h0);
    chk("R5 composed src u0", sa0, 64'h0000_0003_7FFF_FFFF);
    chk("R5 composed src u1", sa1, 64'h0000_0000_7FFF_FFFF);
    chk("R5 composed key u0", ka0, 64'h0000_0001_1234_5670);
    // R6
    wr(8'h2C, 32'hDEAD_BEEF); rd("R6 len", 8'h2C, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    chk("R6 src_len port", len0, 32'hDEAD_BEEF);
    // R7 + R9 without interrupt enable
    wr(8'h30, 32'h0000_0902 & ~32'h200 | 32'h100);
    chk("R7 start pulse", st0, 1); chk("R7 sg_en", sg0, 1); chk("R7 accum", ac0, 1);
    chk("R7 algo", al0, 3'd2); chk("R9 irq off", irq0, 0);
    @(negedge clk); chk("R7 start one cycle", st0, 0);
    rd("R9 done set", 8'h1C, 1, 1);
    // R10 write 0 no effect, write 1 clears
    wr(8'h1C, 32'h0); rd("R10 w0 keeps done", 8'h1C, 1, 1);
    wr(8'h1C, 32'h1); rd("R10 w1 clears done", 8'h1C, 0, 0);
    // R9 with interrupt enable
    wr(8'h30, 32'h0000_0201); chk("R9 irq raised", irq0, 1); chk("R7 start", st0, 1);
    wr(8'h1C, 32'h1); chk("R10 irq dropped", irq0, 0);
    // R8 invalid algorithm
    wr(8'h30, 32'h0000_0205);
    chk("R8 no start", st0, 0); chk("R8 irq", irq0, 1);
    rd("R8 done set", 8'h1C, 1, 1);
    wr(8'h1C, 32'h1);
    // R11 unmapped
    rd("R11 unmapped 0x40", 8'h40, 0, 0);
    rd("R11 window end 0x9C", 8'h9C, 0, 0);
    rd("R11 far 0xFC", 8'hFC, 0, 0);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [7:0] m_read_list [9] = '{8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h90, 8'h94, 8'h98};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule